// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash. It turns one request (program a byte, erase a sector, erase a block or erase the whole array) into the unlock write sequence the flash expects. It then polls the target location until the internal operation has finished. The flash is reached over a simple synchronous bus with a write strobe, a read strobe, a 20-bit address, and separate write-data and read-data bytes. Read data returns in the cycle after the read strobe.

Two completion methods are supported. The first watches bit 6 stop alternating between two back-to-back reads. The second waits for bit 7 to show the true data bit, which is 1 after an erase. A finish seen by either method is accepted only after two more reads both agree with it. This guards against a read that lands on the exact instant the flash completes. One last read of the target is then compared with the value the location should now hold. A per-operation cycle budget, derived from a clock-frequency parameter, turns a flash that never finishes into a timeout.

States: `S_IDLE` waits for a request and goes to `S_CMD` on one. `S_CMD` issues one command write per cycle and moves to `S_POLL_A` after the last write. `S_POLL_A` issues a poll read and goes to `S_POLL_B`. In `S_POLL_B`, the inverted-data method goes to `S_CONF_A` on a finish and back to `S_POLL_A` otherwise; the toggle method issues its second read and goes to `S_POLL_C`. `S_POLL_C` goes to `S_CONF_A` on a finish and to `S_POLL_A` otherwise. The confirmation path runs `S_CONF_A`, then `S_CONF_B`, then `S_CONF_C`. `S_CONF_C` goes to `S_VER_A` if both reads are valid and back to `S_POLL_A` if not. The verify path runs `S_VER_A`, then `S_VER_B`, then `S_IDLE` with done. From any poll or confirmation state, an exhausted budget goes to `S_IDLE` with timeout.

Top module: `flash_pe_sequencer`

## Requirements
- R1: With req_op = 0 (byte program), the block writes exactly four cycles in this order: data AAh at address AAAh, 55h at 555h, A0h at AAAh, and finally the request data at the request address.
- R2: With req_op = 1 (sector), 2 (block) or 3 (chip erase), the block writes exactly six cycles in this order: AAh/AAAh, 55h/555h, 80h/AAAh, AAh/AAAh, 55h/555h. The sixth write is 50h at the request address for a sector, 30h at the request address for a block, and 10h at AAAh for the chip.
- R3: With req_mode = 0 (toggle method), poll reads are issued in pairs at the target address. A pair indicates a finish when bit 6 is equal in both reads.
- R4: With req_mode = 1 (inverted-data method), a single poll read indicates a finish when its bit 7 equals the expected bit. The expected bit is bit 7 of the request data for a program and 1 for any erase.
- R5: After an indicated finish, two more reads of the target are made. Completion is accepted only if both are valid by the active method (bit 6 equal across the two reads for the toggle method, bit 7 correct in both for the inverted-data method); otherwise polling resumes. done is therefore never raised while the flash is still busy, even if one read happens to look finished.
- R6: Polling is bounded by CLK_HZ·20 µs for a program, CLK_HZ·25 ms for a sector or block erase, and CLK_HZ·100 ms for a chip erase, counted from the last command write. When the bound is reached, timeout pulses for one cycle instead of done.
- R7: A request (req_valid high) is taken only while busy is low; requests made while busy are ignored. busy rises in the cycle after acceptance and falls in the cycle where done or timeout pulses. No bus strobe is active while busy is low.
- R8: After confirmation, one final read of the target is compared with the expected contents: the request data for a program, FFh for an erase. verify_fail is high together with the done pulse if they differ.
- R9: While rst_n is low, and in the cycles after it, the block is idle: busy, done, timeout, verify_fail, bus_wr and bus_rd are all low. A reset during an operation abandons it.
- R10: bus_wr and bus_rd are never high in the same cycle, and every read is issued at the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_mode | input | 1 | 0 toggle-bit polling, 1 inverted-data polling |
| req_addr | input | 20 | Target byte, sector or block address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation confirmed finished |
| timeout | output | 1 | One-cycle pulse: budget exhausted |
| verify_fail | output | 1 | Final read mismatched, valid with done |
| bus_wr | output | 1 | Flash bus write strobe |
| bus_rd | output | 1 | Flash bus read strobe |
| bus_addr | output | 20 | Flash bus address |
| bus_wdata | output | 8 | Flash bus write data |
| bus_rdata | input | 8 | Flash bus read data, valid the cycle after bus_rd |

## Verification
Every operation code is paired with both polling methods. The captured write log therefore separates the program sequence from each erase sequence, and shows whether a sector or block address was substituted into the last write. A flash model makes some runs return one read that looks finished while the flash is still busy. For the toggle method, this is a repeated bit 6 inside one read pair. These runs show whether the two-read confirmation is really applied, because a design without it raises done while the model is still busy. A chip erase longer than the program budget, a never-finishing program, and a stored byte that is deliberately corrupted separate the selection of the budget, the timeout path and the final verify from the normal finish.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD,
        S_POLL_A, S_POLL_B, S_POLL_C,
        S_CONF_A, S_CONF_B, S_CONF_C,
        S_VER_A, S_VER_B
    } state_e;

    localparam int STEP_W = 3;
endpackage

// File: rtl/fseq_cmd_rom.sv
module fseq_cmd_rom
    import fseq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  op_e               op,
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     cmd_addr,
    output logic [DW-1:0]     cmd_data,
    output logic              last
);
    localparam logic [AW-1:0] ADR_ONE = AW'(12'hAAA);
    localparam logic [AW-1:0] ADR_TWO = AW'(12'h555);
    localparam logic [DW-1:0] KEY_ONE = DW'(8'hAA);
    localparam logic [DW-1:0] KEY_TWO = DW'(8'h55);

    always_comb begin
        cmd_addr = ADR_ONE;
        cmd_data = KEY_ONE;
        last     = 1'b0;
        case (step)
            3'd0: begin cmd_addr = ADR_ONE; cmd_data = KEY_ONE; end
            3'd1: begin cmd_addr = ADR_TWO; cmd_data = KEY_TWO; end
            3'd2: begin
                cmd_addr = ADR_ONE;
                cmd_data = (op == OP_PROG) ? DW'(8'hA0) : DW'(8'h80);
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    cmd_addr = tgt_addr;
                    cmd_data = tgt_data;
                    last     = 1'b1;
                end else begin
                    cmd_addr = ADR_ONE;
                    cmd_data = KEY_ONE;
                end
            end
            3'd4: begin cmd_addr = ADR_TWO; cmd_data = KEY_TWO; end
            default: begin
                last = 1'b1;
                unique case (op)
                    OP_SECT:  begin cmd_addr = tgt_addr; cmd_data = DW'(8'h50); end
                    OP_BLOCK: begin cmd_addr = tgt_addr; cmd_data = DW'(8'h30); end
                    default:  begin cmd_addr = ADR_ONE;  cmd_data = DW'(8'h10); end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/fseq_poll_eval.sv
module fseq_poll_eval (
    input  logic dbar_mode,
    input  logic exp_msb,
    input  logic prev_msb,
    input  logic cur_msb,
    input  logic prev_tog,
    input  logic cur_tog,
    output logic cur_ok,
    output logic pair_ok
);
    logic msb_cur_good;
    logic tog_still;

    assign msb_cur_good = (cur_msb == exp_msb);
    assign tog_still    = (prev_tog == cur_tog);
    assign cur_ok       = dbar_mode ? msb_cur_good : tog_still;
    assign pair_ok      = dbar_mode ? (msb_cur_good && (prev_msb == exp_msb)) : tog_still;
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
    import fseq_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  op_e  op,
    output logic expired
);
    localparam int PROG_LIM  = (CLK_HZ / 1_000_000) * 20;
    localparam int ERASE_LIM = (CLK_HZ / 1000) * 25;
    localparam int CHIP_LIM  = (CLK_HZ / 1000) * 100;
    localparam int CW        = $clog2(CHIP_LIM + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (op)
            OP_PROG:  lim = CW'(PROG_LIM);
            OP_CHIP:  lim = CW'(CHIP_LIM);
            default:  lim = CW'(ERASE_LIM);
        endcase
    end

    assign expired = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (run && !expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
    import fseq_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 8,
    parameter int CLK_HZ = 50_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic          verify_fail,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    localparam int MSB = DW - 1;
    localparam int TOG = DW - 2;

    state_e            state, nxt;
    logic [STEP_W-1:0] step_q;
    op_e               op_q;
    logic              mode_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     data_q;
    logic [DW-1:0]     prev_q;
    logic              done_q, tout_q, vfail_q;

    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          cmd_last;
    logic          cur_ok, pair_ok, expired;
    logic          exp_msb, polling;
    logic [DW-1:0] exp_final;

    assign exp_msb   = (op_q == OP_PROG) ? data_q[MSB] : 1'b1;
    assign exp_final = (op_q == OP_PROG) ? data_q : {DW{1'b1}};
    assign polling   = (state inside {S_POLL_A, S_POLL_B, S_POLL_C,
                                      S_CONF_A, S_CONF_B, S_CONF_C});

    fseq_cmd_rom #(.AW(AW), .DW(DW)) i_rom (
        .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .last(cmd_last)
    );

    fseq_poll_eval i_eval (
        .dbar_mode(mode_q), .exp_msb(exp_msb),
        .prev_msb(prev_q[MSB]), .cur_msb(bus_rdata[MSB]),
        .prev_tog(prev_q[TOG]), .cur_tog(bus_rdata[TOG]),
        .cur_ok(cur_ok), .pair_ok(pair_ok)
    );

    fseq_timer #(.CLK_HZ(CLK_HZ)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(state == S_CMD && cmd_last),
        .run(polling), .op(op_q), .expired(expired)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = S_CMD;
            S_CMD:    if (cmd_last) nxt = S_POLL_A;
            S_POLL_A: nxt = expired ? S_IDLE : S_POLL_B;
            S_POLL_B: begin
                if (expired)     nxt = S_IDLE;
                else if (!mode_q) nxt = S_POLL_C;
                else             nxt = cur_ok ? S_CONF_A : S_POLL_A;
            end
            S_POLL_C: nxt = expired ? S_IDLE : (cur_ok ? S_CONF_A : S_POLL_A);
            S_CONF_A: nxt = expired ? S_IDLE : S_CONF_B;
            S_CONF_B: nxt = expired ? S_IDLE : S_CONF_C;
            S_CONF_C: nxt = expired ? S_IDLE : (pair_ok ? S_VER_A : S_POLL_A);
            S_VER_A:  nxt = S_VER_B;
            S_VER_B:  nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            step_q <= '0;
            op_q   <= OP_PROG;
            mode_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            prev_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) begin
                op_q   <= op_e'(req_op);
                mode_q <= req_mode;
                addr_q <= req_addr;
                data_q <= req_data;
                step_q <= '0;
            end else if (state == S_CMD) begin
                step_q <= step_q + 1'b1;
            end
            if (state == S_POLL_B || state == S_CONF_B) prev_q <= bus_rdata;
        end
    end

    // result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            tout_q  <= 1'b0;
            vfail_q <= 1'b0;
        end else begin
            done_q  <= (state == S_VER_B);
            vfail_q <= (state == S_VER_B) && (bus_rdata != exp_final);
            tout_q  <= polling && expired;
        end
    end

    // bus outputs
    always_comb begin
        bus_wr    = (state == S_CMD);
        bus_rd    = (state == S_POLL_A) || (state == S_POLL_B && !mode_q) ||
                    (state == S_CONF_A) || (state == S_CONF_B) || (state == S_VER_A);
        bus_addr  = (state == S_CMD) ? cmd_addr : addr_q;
        bus_wdata = (state == S_CMD) ? cmd_data : '0;
    end

    assign busy        = (state != S_IDLE);
    assign done        = done_q;
    assign timeout     = tout_q;
    assign verify_fail = vfail_q;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic          timeout,
    input logic          verify_fail,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [AW-1:0] addr_q
);
    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
    // R10
    rd_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> bus_addr == addr_q);
    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    // R7
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_wr || bus_rd));
    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || timeout));
    // R6
    done_tout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));
    // R8
    vfail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_fail |-> done);
endmodule

bind flash_pe_sequencer fseq_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .done(done), .timeout(timeout), .verify_fail(verify_fail),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .addr_q(addr_q)
);

// File: tb/test_flash_pe_sequencer.sv
module test_flash_pe_sequencer;
    localparam int CLK_HZ   = 10_000_000;
    localparam int PROG_LIM = 200;   // 20 us at 10 MHz
    localparam int NV       = 8;

    typedef struct packed {
        logic [1:0]  op;
        logic        mode;
        logic [19:0] addr;
        logic [7:0]  data;
        logic [15:0] blen;
        logic [7:0]  glit;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 20'h12345, 8'h5A, 16'd20,   8'd0},
        '{2'd0, 1'b1, 20'h00F0F, 8'hA5, 16'd40,   8'd0},
        '{2'd1, 1'b0, 20'h3A123, 8'h00, 16'd60,   8'd0},
        '{2'd2, 1'b1, 20'h70000, 8'h00, 16'd50,   8'd0},
        '{2'd3, 1'b0, 20'h00000, 8'h00, 16'd1000, 8'd0},
        '{2'd0, 1'b1, 20'h00021, 8'h80, 16'd60,   8'd3},
        '{2'd0, 1'b0, 20'h00052, 8'h3C, 16'd60,   8'd2},
        '{2'd1, 1'b1, 20'h5B0C7, 8'h00, 16'd80,   8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_mode = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        busy, done, timeout, verify_fail, bus_wr, bus_rd;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_pe_sequencer #(.CLK_HZ(CLK_HZ)) i_flash_pe_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .timeout(timeout), .verify_fail(verify_fail),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // flash model
    int          busy_len = 0;
    int          glitch_at = 0;
    bit          bad_store = 0;
    int          fl_busy, rcnt, nw, nlog, cyc, lastw;
    logic        tog, fin7, is_prog;
    logic [7:0]  third;
    logic [7:0]  mem   [256];
    logic [19:0] log_a [16];
    logic [7:0]  log_d [16];

    always @(posedge clk) cyc <= cyc + 1;
    initial cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
            fl_busy <= 0; rcnt <= 0; nw <= 0; nlog <= 0; tog <= 1'b0;
            fin7 <= 1'b0; is_prog <= 1'b0; third <= '0; bus_rdata <= '0; lastw <= 0;
        end else begin
            if (fl_busy > 0) fl_busy <= fl_busy - 1;
            if (req_valid && !busy) begin nlog <= 0; nw <= 0; end
            if (bus_wr) begin
                if (nlog < 16) begin log_a[nlog] <= bus_addr; log_d[nlog] <= bus_wdata; end
                nlog  <= nlog + 1;
                nw    <= nw + 1;
                lastw <= cyc;
                if (nw == 2) third <= bus_wdata;
                if (nw == 3 && third == 8'hA0) begin
                    mem[bus_addr[7:0]] <= bus_wdata ^ {7'b0, bad_store};
                    fin7 <= bus_wdata[7]; is_prog <= 1'b1;
                    fl_busy <= busy_len; rcnt <= 0;
                end
                if (nw == 5 && (bus_wdata == 8'h10 || bus_wdata == 8'h50 || bus_wdata == 8'h30)) begin
                    for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
                    is_prog <= 1'b0; fl_busy <= busy_len; rcnt <= 0;
                end
            end
            if (bus_rd) begin
                if (fl_busy > 0) begin
                    rcnt <= rcnt + 1;
                    if (rcnt + 1 == glitch_at)
                        bus_rdata <= {is_prog ? fin7 : 1'b1, ~tog, 6'b0};
                    else begin
                        bus_rdata <= {is_prog ? ~fin7 : 1'b0, tog, 6'b0};
                        tog <= ~tog;
                    end
                end else begin
                    bus_rdata <= mem[bus_addr[7:0]];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [27:0] exp_wr(input logic [1:0] op, input int k,
                                           input logic [19:0] a, input logic [7:0] d);
        logic [27:0] r;
        case (k)
            0: r = {20'hAAA, 8'hAA};
            1: r = {20'h555, 8'h55};
            2: r = {20'hAAA, (op == 2'd0) ? 8'hA0 : 8'h80};
            3: r = (op == 2'd0) ? {a, d} : {20'hAAA, 8'hAA};
            4: r = {20'h555, 8'h55};
            default: r = (op == 2'd1) ? {a, 8'h50} : (op == 2'd2) ? {a, 8'h30} : {20'hAAA, 8'h10};
        endcase
        return r;
    endfunction

    task automatic start(input logic [1:0] op, input logic mode,
                         input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mode = mode; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(input int lim, output bit got_done, output bit got_to);
        int n = 0;
        while (!done && !timeout && n < lim) begin @(negedge clk); n++; end
        got_done = done;
        got_to   = timeout;
    endtask

    task automatic run_vec(input vec_t v);
        bit gd, gt;
        int nexp;
        bit seq_ok;
        string rq;
        busy_len = int'(v.blen); glitch_at = int'(v.glit); bad_store = 0;
        start(v.op, v.mode, v.addr, v.data);
        check(busy == 1'b1, "R7", "busy after accept", 32'(busy), 32'd1);
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 20'h0000F;
        @(negedge clk);
        req_valid = 1'b0;
        wait_end(8000, gd, gt);
        rq = v.mode ? "R4" : "R3";
        check(gd && !gt, rq, "done by polling method", {30'b0, gd, gt}, 32'h2);
        // R5: confirmation means flash has really finished at done
        check(fl_busy == 0, "R5", "flash idle at done", 32'(fl_busy), 32'd0);
        check(verify_fail == 1'b0, "R8", "verify clean", 32'(verify_fail), 32'd0);
        check(busy == 1'b0, "R7", "busy falls with done", 32'(busy), 32'd0);
        nexp = (v.op == 2'd0) ? 4 : 6;
        check(nlog == nexp, "R7", "write count, late request ignored", 32'(nlog), 32'(nexp));
        seq_ok = 1;
        for (int k = 0; k < nexp && k < 16; k++)
            if ({log_a[k], log_d[k]} !== exp_wr(v.op, k, v.addr, v.data)) seq_ok = 0;
        check(seq_ok, (v.op == 2'd0) ? "R1" : "R2", "unlock sequence",
              {log_a[nexp-1], log_d[nexp-1]}, {4'b0, exp_wr(v.op, nexp-1, v.addr, v.data)});
        repeat (3) @(negedge clk);
    endtask

    initial begin
        bit gd, gt;
        int dt;
        repeat (4) @(negedge clk);
        // R9 reset state
        check(!busy && !done && !timeout && !verify_fail && !bus_wr && !bus_rd, "R9",
              "reset idle", {26'b0, busy, done, timeout, verify_fail, bus_wr, bus_rd}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !bus_wr && !bus_rd, "R9", "idle after reset",
              {29'b0, busy, bus_wr, bus_rd}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R8: corrupted store flags a verify failure
        busy_len = 30; glitch_at = 0; bad_store = 1;
        start(2'd0, 1'b1, 20'h00044, 8'h33);
        wait_end(2000, gd, gt);
        check(gd && verify_fail, "R8", "verify_fail on mismatch", {30'b0, gd, verify_fail}, 32'h3);
        bad_store = 0;
        repeat (3) @(negedge clk);

        // R6: flash never finishes, program budget
        busy_len = 1_000_000;
        start(2'd0, 1'b0, 20'h00077, 8'h11);
        wait_end(2000, gd, gt);
        dt = cyc - lastw;
        check(gt && !gd, "R6", "timeout instead of done", {30'b0, gd, gt}, 32'h1);
        check(dt >= PROG_LIM && dt <= PROG_LIM + 8, "R6", "timeout latency", 32'(dt), 32'(PROG_LIM));
        @(negedge clk);
        check(!busy && !timeout, "R6", "timeout is one-cycle, then idle", {30'b0, busy, timeout}, 32'd0);

        // R9: reset mid-operation abandons it
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        busy_len = 500;
        start(2'd3, 1'b1, 20'h00000, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!busy && !bus_wr && !bus_rd, "R9", "reset aborts", {29'b0, busy, bus_wr, bus_rd}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: reads always at target (sampled over a short program)
        busy_len = 10;
        start(2'd0, 1'b1, 20'h000AB, 8'h0F);
        begin
            bit addr_ok = 1;
            bit strobe_ok = 1;
            int n = 0;
            while (!done && !timeout && n < 500) begin
                if (bus_rd && bus_addr != 20'h000AB) addr_ok = 0;
                if (bus_rd && bus_wr) strobe_ok = 0;
                @(negedge clk); n++;
            end
            check(addr_ok && strobe_ok, "R10", "read address and strobes",
                  {30'b0, addr_ok, strobe_ok}, 32'h3);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule